// File: doc/BRIEF.md
# MMU Control Register Bank

This block holds the memory-management and exception-reporting registers of a processor core behind a simple single-cycle register bus. It has nine 32-bit registers: a translation control word, the high and low halves of a page-table entry, an entry-assistance word, a translation table base, a faulting address, a trap code, and two event codes (exception and interrupt). Some of them keep only a low slice of what is written. All of them read back through the same bus.

Two writes also act as commands for a translation buffer that sits outside this block. A control write with the invalidate bit set sends a one-cycle invalidate-all pulse, and that bit is never stored. A write to the entry-high register that changes its low 8-bit address-space identifier sends a one-cycle flush pulse. Only full-word accesses are legal. Any other size, and any offset that does not name a register, sets a sticky error flag and leaves every register as it was.

Top module: `mmu_ctl_bank`

## Requirements
- R1: After reset all nine registers read 0, `err_sticky` is 0, and neither pulse output rises during reset or in the cycle after it.
- R2: A legal control write (offset 0x00) with bit INVAL_BIT of the data set raises `tlb_inval_pulse` for exactly the one cycle after the write edge. The stored value has that bit cleared and all other bits as written.
- R3: A legal control write with bit INVAL_BIT clear raises no invalidate pulse. Any other set bit, including bit 2 when INVAL_BIT is not 2, is stored.
- R4: A legal write to entry-high (offset 0x04) raises `tlb_flush_pulse` for one cycle if and only if data bits [7:0] differ from the stored bits [7:0]. All 32 bits are then stored.
- R5: Entry-assistance (offset 0x0C) keeps only bits [3:0]. The upper bits read 0.
- R6: Trap code (0x18), exception event (0x1C) and interrupt event (0x20) each keep only bits [10:0].
- R7: Entry-low (0x08), table base (0x10) and fault address (0x14) store all 32 bits unchanged.
- R8: `req_size` encodes 0 = byte, 1 = halfword, 2 = word. A non-word access sets `err_sticky`, changes no register and raises no pulse. A non-word read responds with data 0.
- R9: An access whose offset is not word aligned, or that lies beyond 0x20, sets `err_sticky` and changes no register. Such a read responds with data 0.
- R10: A read accepted at a clock edge gives `rsp_valid` high for the next cycle, with `rsp_rdata` holding the register value from before that edge. Writes never raise `rsp_valid`.
- R11: Once set, `err_sticky` stays high until reset, whatever legal accesses follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the bank |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| err_sticky | output | 1 | Sticky illegal-access flag |
| tlb_inval_pulse | output | 1 | One-cycle invalidate-all command |
| tlb_flush_pulse | output | 1 | One-cycle flush command on identifier change |

## Verification
The bench builds the bank with INVAL_BIT = 0 rather than the default 2. This puts the self-clearing bit at the very edge of the mask logic. It also lets the bench show that bit 2 of the control word is then stored like any other bit and fires nothing. ADDR_W stays at 8, so offsets past the last register, such as 0x24 and 0xFC, are reachable and exercise the unmapped-offset error. The entry-high vectors step the identifier through unchanged, changed and unchanged-with-new-upper-bits writes, which separates the flush compare from a whole-word compare.

// File: rtl/mmureg_pkg.sv
// Package: shared constants, access-size encoding, register indices and the
// per-register keep-mask used by the MMU control register bank.
// Assumes 32-bit registers placed on consecutive word offsets from 0.
package mmureg_pkg;

    localparam int DW       = 32;
    localparam int NUM_REGS = 9;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [IDX_W-1:0] {
        RI_CTRL   = 4'd0,
        RI_ENT_HI = 4'd1,
        RI_ENT_LO = 4'd2,
        RI_ASSIST = 4'd3,
        RI_TBASE  = 4'd4,
        RI_FADDR  = 4'd5,
        RI_TRAP   = 4'd6,
        RI_XEVT   = 4'd7,
        RI_IEVT   = 4'd8
    } reg_idx_e;

    // Bits of a written value that a given register keeps.
    function automatic logic [DW-1:0] keep_mask(input int idx, input int inval_bit,
                                                input int assist_w, input int evt_w);
        case (idx)
            0:       return ~(DW'(1) << inval_bit);
            3:       return (DW'(1) << assist_w) - DW'(1);
            6, 7, 8: return (DW'(1) << evt_w) - DW'(1);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/mmureg_decode.sv
// Module: access decoder. Turns a byte offset and size into a register index
// and a legality flag. Assumes ADDR_W >= IDX_W + 2 and word-aligned registers.
module mmureg_decode
    import mmureg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              legal,
    output logic [IDX_W-1:0]  idx
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] word_idx;
    logic              aligned;
    logic              in_range;

    // Split the offset and judge each legality condition.
    always_comb begin
        word_idx = addr[ADDR_W-1:2];
        aligned  = (addr[1:0] == 2'b00);
        in_range = (word_idx < WIDX_W'(NUM_REGS));
        legal    = aligned && in_range && (size == SZ_WORD);
        idx      = word_idx[IDX_W-1:0];
    end
endmodule

// File: rtl/mmureg_file.sv
// Module: register storage. One register per index, each keeping only the
// bits its mask allows. Assumes a single write port and synchronous reset.
module mmureg_file
    import mmureg_pkg::*;
#(
    parameter int INVAL_BIT = 2,
    parameter int ASSIST_W  = 4,
    parameter int EVT_W     = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IDX_W-1:0]             widx,
    input  logic [DW-1:0]                wdata,
    output logic [NUM_REGS-1:0][DW-1:0]  q
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [DW-1:0] KEEP = keep_mask(g, INVAL_BIT, ASSIST_W, EVT_W);

        // Clear on reset, otherwise capture masked data on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                q[g] <= wdata & KEEP;
            end
        end
    end
endmodule

// File: rtl/mmureg_side.sv
// Module: side-effect pulse generator. Raises a one-cycle invalidate pulse on
// a control write carrying the invalidate bit, and a one-cycle flush pulse on
// an entry-high write that changes the address-space identifier. Assumes the
// caller qualifies `we` with legality and `cur_asid` is the stored value.
module mmureg_side
    import mmureg_pkg::*;
#(
    parameter int INVAL_BIT = 2,
    parameter int ASID_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DW-1:0]     wdata,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              inval_pulse,
    output logic              flush_pulse
);
    logic inval_d;
    logic flush_d;

    // Decide which command the current write asks for.
    always_comb begin
        inval_d = we && (widx == RI_CTRL) && wdata[INVAL_BIT];
        flush_d = we && (widx == RI_ENT_HI) && (wdata[ASID_W-1:0] != cur_asid);
    end

    // Register the commands so each lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inval_pulse <= 1'b0;
            flush_pulse <= 1'b0;
        end else begin
            inval_pulse <= inval_d;
            flush_pulse <= flush_d;
        end
    end
endmodule

// File: rtl/mmu_ctl_bank.sv
// Module: MMU control register bank top. Decodes bus accesses, updates the
// register file, generates maintenance pulses and returns registered read
// data. Illegal accesses set a sticky flag and touch nothing. Assumes one
// access per cycle and that reads have no side effects.
module mmu_ctl_bank
    import mmureg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int INVAL_BIT = 2,
    parameter int ASID_W    = 8,
    parameter int ASSIST_W  = 4,
    parameter int EVT_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              err_sticky,
    output logic              tlb_inval_pulse,
    output logic              tlb_flush_pulse
);
    logic                        legal;
    logic [IDX_W-1:0]            idx;
    logic                        wr_ok;
    logic [NUM_REGS-1:0][DW-1:0] regs;
    logic [DW-1:0]               rd_mux;

    mmureg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (req_addr),
        .size  (req_size),
        .legal (legal),
        .idx   (idx)
    );

    // Qualify writes with validity and legality.
    assign wr_ok = req_valid && req_write && legal;

    mmureg_file #(
        .INVAL_BIT (INVAL_BIT),
        .ASSIST_W  (ASSIST_W),
        .EVT_W     (EVT_W)
    ) u_file (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok),
        .widx  (idx),
        .wdata (req_wdata),
        .q     (regs)
    );

    mmureg_side #(
        .INVAL_BIT (INVAL_BIT),
        .ASID_W    (ASID_W)
    ) u_side (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (wr_ok),
        .widx        (idx),
        .wdata       (req_wdata),
        .cur_asid    (regs[RI_ENT_HI][ASID_W-1:0]),
        .inval_pulse (tlb_inval_pulse),
        .flush_pulse (tlb_flush_pulse)
    );

    // Select read data, forcing 0 for an illegal access.
    always_comb begin
        rd_mux = '0;
        if (legal) begin
            rd_mux = regs[idx];
        end
    end

    // Register the read response and track the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            err_sticky <= 1'b0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                rsp_rdata <= rd_mux;
            end
            if (req_valid && !legal) begin
                err_sticky <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mmu_ctl_bank_chk.sv
// Module: property checker for the MMU control register bank, bound to the top.
// Observes only the top-level ports.
module mmu_ctl_bank_chk #(
    parameter int ADDR_W    = 8,
    parameter int INVAL_BIT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              err_sticky,
    input logic              tlb_inval_pulse,
    input logic              tlb_flush_pulse
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!tlb_inval_pulse && !tlb_flush_pulse && !err_sticky && !rsp_valid));

    // R2
    inval_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inval_pulse |-> $past(req_valid && req_write && req_size == 2'd2
                                  && req_addr == ADDR_W'(0) && req_wdata[INVAL_BIT]));

    // R2
    inval_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inval_pulse |=> !tlb_inval_pulse || $past(req_valid && req_write));

    // R4
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_pulse |-> $past(req_valid && req_write && req_size == 2'd2
                                  && req_addr == ADDR_W'(4)));

    // R8
    bad_size_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size != 2'd2) |=> (rsp_valid && rsp_rdata == 32'd0 && err_sticky));

    // R10
    rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    // R11
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);
endmodule

bind mmu_ctl_bank mmu_ctl_bank_chk #(.ADDR_W(ADDR_W), .INVAL_BIT(INVAL_BIT)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_write       (req_write),
    .req_addr        (req_addr),
    .req_size        (req_size),
    .req_wdata       (req_wdata),
    .rsp_valid       (rsp_valid),
    .rsp_rdata       (rsp_rdata),
    .err_sticky      (err_sticky),
    .tlb_inval_pulse (tlb_inval_pulse),
    .tlb_flush_pulse (tlb_flush_pulse)
);

// File: tb/tb_mmu_ctl_bank.sv
module tb_mmu_ctl_bank;
    localparam int AW  = 8;
    localparam int INV = 0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [1:0]  req_size;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        err_sticky, tlb_inval_pulse, tlb_flush_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mmu_ctl_bank #(.ADDR_W(AW), .INVAL_BIT(INV)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_sticky(err_sticky),
        .tlb_inval_pulse(tlb_inval_pulse), .tlb_flush_pulse(tlb_flush_pulse)
    );

    // {offset, write data, expected readback, expect invalidate, expect flush}
    localparam int NV = 12;
    localparam logic [73:0] VEC [NV] = '{
        {8'h00, 32'h0000_0105, 32'h0000_0104, 1'b1, 1'b0},  // R2
        {8'h00, 32'h0000_0104, 32'h0000_0104, 1'b0, 1'b0},  // R3
        {8'h04, 32'h1234_5600, 32'h1234_5600, 1'b0, 1'b0},  // R4 same id
        {8'h04, 32'h1234_56A5, 32'h1234_56A5, 1'b0, 1'b1},  // R4 new id
        {8'h04, 32'hFFFF_FFA5, 32'hFFFF_FFA5, 1'b0, 1'b0},  // R4 upper only
        {8'h08, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b0},  // R7
        {8'h0C, 32'hFFFF_FFFF, 32'h0000_000F, 1'b0, 1'b0},  // R5
        {8'h10, 32'h8000_0001, 32'h8000_0001, 1'b0, 1'b0},  // R7
        {8'h14, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 1'b0, 1'b0},  // R7
        {8'h18, 32'hFFFF_FFFF, 32'h0000_07FF, 1'b0, 1'b0},  // R6
        {8'h1C, 32'h0000_1A40, 32'h0000_0240, 1'b0, 1'b0},  // R6
        {8'h20, 32'hFFFF_F9E0, 32'h0000_01E0, 1'b0, 1'b0}   // R6
    };

    logic        s_inv, s_fl, s_rv;
    logic [31:0] s_rd;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        s_inv = tlb_inval_pulse; s_fl = tlb_flush_pulse; s_rv = rsp_valid; s_rd = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = 2'd2; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = 2'd2; req_wdata = '0;
        do_reset();

        // R1 reset state
        check("R1 err", 32'(err_sticky), 0);
        check("R1 inval", 32'(tlb_inval_pulse), 0);
        check("R1 flush", 32'(tlb_flush_pulse), 0);
        for (int i = 0; i < 9; i++) begin
            access(1'b0, AW'(i * 4), 2'd2, 32'd0);
            check("R1 reg", s_rd, 0);
        end

        // Vector walk: write, check pulses, read back
        for (int i = 0; i < NV; i++) begin
            access(1'b1, VEC[i][73:66], 2'd2, VEC[i][65:34]);
            check("R2 inval pulse", 32'(s_inv), 32'(VEC[i][1]));
            check("R4 flush pulse", 32'(s_fl), 32'(VEC[i][0]));
            check("R10 write no rsp", 32'(s_rv), 0);
            access(1'b0, VEC[i][73:66], 2'd2, 32'd0);
            check("R10 rsp valid", 32'(s_rv), 1);
            check("R5 R6 R7 readback", s_rd, VEC[i][33:2]);
        end

        // R2 pulse lasts one cycle
        access(1'b1, 8'h00, 2'd2, 32'h1);
        @(negedge clk);
        check("R2 pulse width", 32'(tlb_inval_pulse), 0);
        access(1'b0, 8'h00, 2'd2, 32'd0);
        check("R2 bit cleared", s_rd, 0);

        // R3 bit 2 is ordinary when invalidate bit is 0
        access(1'b1, 8'h00, 2'd2, 32'h4);
        check("R3 no pulse", 32'(s_inv), 0);
        access(1'b0, 8'h00, 2'd2, 32'd0);
        check("R3 bit2 stored", s_rd, 32'h4);
        check("R8 err before bad", 32'(err_sticky), 0);

        // R8 bad size write to ctrl with invalidate bit: no pulse, no change
        access(1'b1, 8'h00, 2'd1, 32'hFFFF_FFFF);
        check("R8 no pulse", 32'(s_inv), 0);
        check("R8 err set", 32'(err_sticky), 1);
        access(1'b0, 8'h00, 2'd2, 32'd0);
        check("R8 ctrl unchanged", s_rd, 32'h4);
        // R8 bad size write to entry-high with new id: no flush
        access(1'b1, 8'h04, 2'd0, 32'h0000_0011);
        check("R8 no flush", 32'(s_fl), 0);
        access(1'b0, 8'h04, 2'd2, 32'd0);
        check("R8 enthi unchanged", s_rd, 32'hFFFF_FFA5);
        // R8 bad size read returns 0
        access(1'b0, 8'h10, 2'd1, 32'd0);
        check("R8 rsp valid", 32'(s_rv), 1);
        check("R8 bad read data", s_rd, 0);

        // R9 unmapped and misaligned, after a fresh reset
        do_reset();
        access(1'b1, 8'h10, 2'd2, 32'h0000_00AA);
        access(1'b1, 8'h24, 2'd2, 32'hFFFF_FFFF);
        check("R9 err unmapped", 32'(err_sticky), 1);
        access(1'b1, 8'h12, 2'd2, 32'h5555_5555);
        access(1'b0, 8'h10, 2'd2, 32'd0);
        check("R9 tbase unchanged", s_rd, 32'hAA);
        access(1'b0, 8'hFC, 2'd2, 32'd0);
        check("R9 unmapped read", s_rd, 0);
        access(1'b0, 8'h11, 2'd2, 32'd0);
        check("R9 misaligned read", s_rd, 0);

        // R11 sticky across legal traffic
        repeat (3) access(1'b1, 8'h14, 2'd2, 32'h1);
        check("R11 err held", 32'(err_sticky), 1);
        do_reset();
        check("R11 cleared by reset", 32'(err_sticky), 0);
        access(1'b0, 8'h10, 2'd2, 32'd0);
        check("R1 reg after reset", s_rd, 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule